// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits on the controller side of a double-data-rate SDRAM interface. It takes single read or write requests, each naming a bank, a row, a column and a direction, and turns them into a legal series of device commands on four active-low strobes: chip select, row strobe, column strobe and write enable. It also drives a bank select and an address bus. The block keeps one open row per bank across four banks. A request to the row that is already open goes straight to its column command. A request to a different row first closes the bank, then opens the new row. Idle cycles are inserted wherever a timing gap is still running.

All spacing is counted in clock cycles and comes from configuration inputs: activate-to-column delay, precharge recovery, refresh recovery, CAS latency (2 or 3) and burst length (4 or 8). An interval counter, sized from the clock frequency so that every row is refreshed within 64 ms, raises a refresh deadline. That deadline takes priority over pending work. Every open bank is closed, the precharge recovery is waited out, and an AUTO REFRESH is issued. No row is opened again until the refresh recovery has expired. A strobe output marks the cycle in which the first read data is due. Data pins, strobe timing and capture are left to the physical layer.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Commands use the strobe encoding {cs_n,ras_n,cas_n,we_n}: ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001. Any cycle with no command drives 1111. No other pattern appears.
- R2: While reset is asserted and in the first cycle after it, the strobes are 1111, rd_start is low and req_ready is high.
- R3: A READ or WRITE to a bank comes at least cfg_trcd cycles after that bank's ACTIVATE. For a request to a closed, recovered bank, the ACTIVATE comes one cycle after acceptance and the column command exactly cfg_trcd cycles after the ACTIVATE.
- R4: An ACTIVATE comes at least cfg_trp cycles after a PRECHARGE of the same bank, and at least cfg_trfc cycles after an AUTO REFRESH.
- R5: A request that hits the open row of its bank issues only its column command, one cycle after acceptance. A request to another row of an open bank issues PRECHARGE, then ACTIVATE cfg_trp cycles later, then the column command. ACTIVATE is never sent to an open bank, and READ, WRITE and PRECHARGE are sent only to open banks.
- R6: The four banks hold open rows independently. Opening or closing one bank leaves the others' rows open.
- R7: rd_start pulses exactly 2 cycles after a READ when cfg_cl3 is 0, and exactly 3 cycles after when it is 1.
- R8: After a READ or WRITE, the next READ, WRITE or PRECHARGE waits half the burst length: 2 cycles when cfg_bl8 is 0 and 4 when it is 1. Back-to-back hits are spaced by exactly that amount.
- R9: Every REF_INTERVAL cycles a refresh becomes due. All open banks are then precharged, lowest bank number first, in consecutive cycles. AUTO REFRESH follows exactly cfg_trp cycles after the last of these precharges, with every bank closed. When no bank is open and nothing else is busy, successive refreshes are exactly REF_INTERVAL cycles apart.
- R10: req_ready is low while a request is held, while a refresh is due, and until cfg_trfc-1 cycles after an AUTO REFRESH. In the cycle after that it is high again.
- R11: ACTIVATE drives the row on addr. READ and WRITE drive the zero-extended column. ba carries the request's bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken on a rising edge with req_valid high |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_bank | input | 2 | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| cfg_trcd | input | T_W | Activate-to-column cycles |
| cfg_trp | input | T_W | Precharge recovery cycles |
| cfg_trfc | input | T_W | Refresh recovery cycles |
| cfg_cl3 | input | 1 | CAS latency 3 when high, 2 when low |
| cfg_bl8 | input | 1 | Burst of 8 when high, 4 when low |
| cs_n | output | 1 | Chip select strobe |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write enable strobe |
| ba | output | 2 | Bank select |
| addr | output | ROW_W | Row or column address |
| rd_start | output | 1 | First read data is due in this cycle |

## Verification
The hardest case to reach from the ports is a refresh deadline that lands while all four banks hold open rows. Reaching it means driving a closing sequence that covers every bank, in order, and then a refresh gap followed by a reopen. The stimulus table leaves each bank open on a different row. The bench then lets the shortened refresh interval expire. It checks the order of the precharges, the exact spacing to the refresh, the window in which ready stays low, and that the next request has to open its bank again. Two later idle refreshes measure the interval itself.

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int T_W = 4,
  parameter int CLK_MHZ = 133,
  parameter int RETAIN_MS = 64,
  parameter int ROWS_PER_SWEEP = 8192,
  parameter int REF_INTERVAL = CLK_MHZ * RETAIN_MS * 1000 / ROWS_PER_SWEEP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [T_W-1:0]   cfg_trcd,
  input  logic [T_W-1:0]   cfg_trp,
  input  logic [T_W-1:0]   cfg_trfc,
  input  logic             cfg_cl3,
  input  logic             cfg_bl8,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [1:0]       ba,
  output logic [ROW_W-1:0] addr,
  output logic             rd_start
);
  localparam int NB = 4;
  localparam int BA_W = 2;
  localparam int RT_W = $clog2(REF_INTERVAL + 1);
  localparam logic [3:0] C_NOP = 4'b1111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;

  function automatic logic [T_W-1:0] first_wait(input logic [T_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  logic             open_q  [NB];
  logic [ROW_W-1:0] row_q   [NB];
  logic [T_W-1:0]   rcd_cnt [NB];
  logic [T_W-1:0]   rp_cnt  [NB];
  logic [NB-1:0]    rcd_zero, rp_zero;
  logic [T_W-1:0]   rfc_cnt;
  logic [2:0]       col_cnt;
  logic [RT_W-1:0]  ref_tmr;
  logic             ref_pend;

  logic             held_v, h_wr;
  logic [BA_W-1:0]  h_bank;
  logic [ROW_W-1:0] h_row;
  logic [COL_W-1:0] h_col;

  logic [3:0]       cmd_q, nxt_cmd;
  logic [BA_W-1:0]  ba_q, nxt_ba, lo_bank;
  logic [ROW_W-1:0] addr_q, nxt_addr;
  logic [3:0]       rd_pipe;
  logic             any_open;

  wire col_free = (col_cnt == 3'd0);
  wire rfc_free = (rfc_cnt == '0);
  wire nxt_col  = (nxt_cmd == C_RD) || (nxt_cmd == C_WR);

  assign req_ready = !held_v && !ref_pend && rfc_free;
  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign ba = ba_q;
  assign addr = addr_q;
  assign rd_start = cfg_cl3 ? rd_pipe[3] : rd_pipe[2];

  always_comb begin
    lo_bank = '0;
    any_open = 1'b0;
    for (int b = NB - 1; b >= 0; b--) begin
      if (open_q[b]) begin
        lo_bank = BA_W'(b);
        any_open = 1'b1;
      end
    end
  end

  always_comb begin
    nxt_cmd = C_NOP;
    nxt_ba = h_bank;
    nxt_addr = '0;
    if (ref_pend) begin
      nxt_ba = '0;
      if (any_open) begin
        if (col_free) begin
          nxt_cmd = C_PRE;
          nxt_ba = lo_bank;
        end
      end else if ((&rp_zero) && rfc_free) begin
        nxt_cmd = C_REF;
      end
    end else if (held_v) begin
      if (open_q[h_bank] && row_q[h_bank] == h_row) begin
        if (rcd_zero[h_bank] && col_free) begin
          nxt_cmd = h_wr ? C_WR : C_RD;
          nxt_addr = ROW_W'(h_col);
        end
      end else if (open_q[h_bank]) begin
        if (col_free) nxt_cmd = C_PRE;
      end else if (rp_zero[h_bank] && rfc_free) begin
        nxt_cmd = C_ACT;
        nxt_addr = h_row;
      end
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic act_g, pre_g;
    assign act_g = (nxt_cmd == C_ACT) && (nxt_ba == BA_W'(g));
    assign pre_g = (nxt_cmd == C_PRE) && (nxt_ba == BA_W'(g));
    assign rcd_zero[g] = (rcd_cnt[g] == '0);
    assign rp_zero[g] = (rp_cnt[g] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[g]  <= 1'b0;
        row_q[g]   <= '0;
        rcd_cnt[g] <= '0;
        rp_cnt[g]  <= '0;
      end else begin
        if (act_g) begin
          open_q[g] <= 1'b1;
          row_q[g] <= nxt_addr;
        end else if (pre_g) begin
          open_q[g] <= 1'b0;
        end
        if (act_g) rcd_cnt[g] <= first_wait(cfg_trcd);
        else if (!rcd_zero[g]) rcd_cnt[g] <= rcd_cnt[g] - 1'b1;
        if (pre_g) rp_cnt[g] <= first_wait(cfg_trp);
        else if (!rp_zero[g]) rp_cnt[g] <= rp_cnt[g] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= C_NOP;
      ba_q     <= '0;
      addr_q   <= '0;
      rd_pipe  <= '0;
      rfc_cnt  <= '0;
      col_cnt  <= '0;
      ref_tmr  <= RT_W'(REF_INTERVAL - 1);
      ref_pend <= 1'b0;
      held_v   <= 1'b0;
      h_wr     <= 1'b0;
      h_bank   <= '0;
      h_row    <= '0;
      h_col    <= '0;
    end else begin
      cmd_q   <= nxt_cmd;
      ba_q    <= nxt_ba;
      addr_q  <= nxt_addr;
      rd_pipe <= {rd_pipe[2:0], nxt_cmd == C_RD};

      if (nxt_cmd == C_REF) rfc_cnt <= first_wait(cfg_trfc);
      else if (!rfc_free) rfc_cnt <= rfc_cnt - 1'b1;

      if (nxt_col) col_cnt <= cfg_bl8 ? 3'd3 : 3'd1;
      else if (!col_free) col_cnt <= col_cnt - 3'd1;

      if (ref_tmr == '0) begin
        ref_tmr <= RT_W'(REF_INTERVAL - 1);
        ref_pend <= 1'b1;
      end else begin
        ref_tmr <= ref_tmr - 1'b1;
        if (nxt_cmd == C_REF) ref_pend <= 1'b0;
      end

      if (req_valid && req_ready) begin
        held_v <= 1'b1;
        h_wr   <= req_write;
        h_bank <= req_bank;
        h_row  <= req_row;
        h_col  <= req_col;
      end else if (nxt_col) begin
        held_v <= 1'b0;
      end
    end
  end

  p_col_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_RD || cmd_q == C_WR || cmd_q == C_PRE) |-> $past(open_q[ba]) || cmd_q == C_PRE && open_q[ba] == 1'b0);

  p_act_row_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_ACT) |-> open_q[ba] && row_q[ba] == addr);

  p_ref_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_REF) |-> !any_open);

  p_col_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_RD || cmd_q == C_WR) |=> !(cmd_q == C_RD || cmd_q == C_WR || cmd_q == C_PRE));

  p_rd_cl2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_RD && !cfg_cl3) |-> ##2 rd_start);

  p_rd_cl3_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_RD && cfg_cl3) |-> ##3 rd_start);

  p_ready_rfc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_REF && cfg_trfc > 1) |-> !req_ready);

endmodule

// File: tb/sdram_cmd_seq_bench.sv
module sdram_cmd_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 13;
  localparam int COL_W = 10;
  localparam int T_W = 4;
  localparam int REF_IVL = 1500;
  localparam int TRCD = 3;
  localparam int TRP = 2;
  localparam int TRFC = 6;
  localparam int NV = 10;

  // {write, bank[2], row[13], col[10], class[2] (0 hit,1 closed,2 miss), cl3, bl8}
  localparam logic [29:0] VEC [NV] = '{
    {1'b0, 2'd0, 13'd5,    10'd12,   2'd1, 1'b0, 1'b0},
    {1'b1, 2'd1, 13'd7,    10'd3,    2'd1, 1'b0, 1'b0},
    {1'b0, 2'd0, 13'd5,    10'd20,   2'd0, 1'b1, 1'b0},
    {1'b0, 2'd1, 13'd7,    10'd40,   2'd0, 1'b1, 1'b1},
    {1'b1, 2'd0, 13'd9,    10'd1,    2'd2, 1'b0, 1'b1},
    {1'b0, 2'd2, 13'd1,    10'd1023, 2'd1, 1'b1, 1'b0},
    {1'b0, 2'd3, 13'd2,    10'd0,    2'd1, 1'b0, 1'b0},
    {1'b1, 2'd2, 13'd1,    10'd7,    2'd0, 1'b0, 1'b1},
    {1'b0, 2'd3, 13'd8191, 10'd5,    2'd2, 1'b1, 1'b0},
    {1'b0, 2'd0, 13'd9,    10'd9,    2'd0, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [T_W-1:0] cfg_trcd = T_W'(TRCD), cfg_trp = T_W'(TRP), cfg_trfc = T_W'(TRFC);
  logic cfg_cl3 = 1'b0, cfg_bl8 = 1'b0;
  logic req_ready, cs_n, ras_n, cas_n, we_n, rd_start;
  logic [1:0] ba;
  logic [ROW_W-1:0] addr;

  sdram_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .T_W(T_W), .REF_INTERVAL(REF_IVL)) u_sdram_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp), .cfg_trfc(cfg_trfc), .cfg_cl3(cfg_cl3),
    .cfg_bl8(cfg_bl8), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .rd_start(rd_start));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  int last_act [4], last_pre [4];
  int last_col = -1000, prev_col = -1000, last_ref = -1000;
  bit sb_open [4];
  logic [ROW_W-1:0] sb_row [4];
  int n_act = 0, n_pre = 0, n_col = 0, n_ref = 0, n_pre_ref = 0;
  bit col_seen = 1'b0, col_wr = 1'b0;
  int col_cyc = 0;
  logic [1:0] col_ba;
  logic [ROW_W-1:0] col_addr;
  int pre_log [8];
  int ref_log [4];
  logic [63:0] rd_due = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] c;
      int b, bl2, cl, mx;
      c = {cs_n, ras_n, cas_n, we_n};
      b = int'(ba);
      bl2 = cfg_bl8 ? 4 : 2;
      cl = cfg_cl3 ? 3 : 2;
      if (rd_start || rd_due[cyc % 64]) chk(rd_start == rd_due[cyc % 64], "R7 rd_start timing", rd_start, rd_due[cyc % 64]);
      rd_due[cyc % 64] = 1'b0;
      case (c)
        4'b1111: ;
        4'b0011: begin
          chk(!sb_open[b], "R5 activate to open bank", sb_open[b], 0);
          chk(cyc - last_pre[b] >= TRP, "R4 precharge to activate", cyc - last_pre[b], TRP);
          chk(cyc - last_ref >= TRFC, "R4 refresh to activate", cyc - last_ref, TRFC);
          sb_open[b] = 1'b1;
          sb_row[b] = addr;
          last_act[b] = cyc;
          n_act++;
        end
        4'b0101, 4'b0100: begin
          chk(sb_open[b], "R5 column to closed bank", sb_open[b], 1);
          chk(cyc - last_act[b] >= TRCD, "R3 activate to column", cyc - last_act[b], TRCD);
          chk(cyc - last_col >= bl2, "R8 column spacing", cyc - last_col, bl2);
          prev_col = last_col;
          last_col = cyc;
          n_col++;
          col_seen = 1'b1;
          col_cyc = cyc;
          col_ba = ba;
          col_addr = addr;
          col_wr = (c == 4'b0100);
          if (c == 4'b0101) rd_due[(cyc + cl) % 64] = 1'b1;
        end
        4'b0010: begin
          chk(sb_open[b], "R5 precharge of closed bank", sb_open[b], 1);
          chk(cyc - last_col >= bl2, "R8 column to precharge", cyc - last_col, bl2);
          sb_open[b] = 1'b0;
          last_pre[b] = cyc;
          n_pre++;
          if (n_pre_ref < 8) pre_log[n_pre_ref] = b;
          n_pre_ref++;
        end
        4'b0001: begin
          mx = -1000;
          for (int i = 0; i < 4; i++) begin
            chk(!sb_open[i], "R9 refresh with open bank", sb_open[i], 0);
            if (last_pre[i] > mx) mx = last_pre[i];
          end
          chk(cyc - mx == TRP || mx < 0 || cyc - mx > TRP + 2, "R9 precharge to refresh", cyc - mx, TRP);
          chk(!req_ready, "R10 ready during refresh", req_ready, 0);
          last_ref = cyc;
          if (n_ref < 4) ref_log[n_ref] = cyc;
          n_ref++;
        end
        default: chk(1'b0, "R1 illegal strobe pattern", int'(c), 15);
      endcase
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic offer(input bit w, input logic [1:0] b, input logic [ROW_W-1:0] r,
                       input logic [COL_W-1:0] c, output int acc);
    int wd;
    req_write = w; req_bank = b; req_row = r; req_col = c; req_valid = 1'b1;
    wd = 0;
    while (!req_ready && wd < 300) begin @(negedge clk); wd++; end
    acc = cyc + 1;
    n_act = 0; n_pre = 0; col_seen = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_col(input int target);
    int wd;
    wd = 0;
    while (n_col < target && wd < 300) begin @(posedge clk); wd++; end
  endtask

  task automatic run_vec(input logic [29:0] v, input int idx);
    int acc, exp_lat, cls, base;
    idle(6);
    cfg_cl3 = v[1]; cfg_bl8 = v[0];
    idle(6);
    cls = int'(v[3:2]);
    base = n_col;
    offer(v[29], v[28:27], v[26:14], v[13:4], acc);
    chk(!req_ready, "R10 ready low while held", req_ready, 0);
    wait_col(base + 1);
    exp_lat = (cls == 0) ? 1 : (cls == 1) ? 1 + TRCD : 1 + TRP + TRCD;
    chk(col_cyc - acc == exp_lat, (cls == 0) ? "R5 hit latency" : (cls == 1) ? "R3 closed-bank latency" : "R5 miss latency", col_cyc - acc, exp_lat);
    chk(n_act == (cls == 0 ? 0 : 1), "R1 activate count", n_act, cls == 0 ? 0 : 1);
    chk(n_pre == (cls == 2 ? 1 : 0), "R5 precharge count", n_pre, cls == 2 ? 1 : 0);
    chk(col_ba == v[28:27], "R11 column bank", int'(col_ba), int'(v[28:27]));
    chk(col_addr == ROW_W'(v[13:4]), "R11 column address", int'(col_addr), int'(v[13:4]));
    chk(col_wr == v[29], "R1 read/write strobe", col_wr, v[29]);
    chk(sb_row[v[28:27]] == v[26:14], "R11 activated row", int'(sb_row[v[28:27]]), int'(v[26:14]));
    if (idx == 3) chk(sb_open[0] && sb_open[1], "R6 both banks open", sb_open[0] + sb_open[1], 2);
  endtask

  task automatic run_pair(input bit bl8);
    int acc, base, gap;
    idle(6);
    cfg_bl8 = bl8; cfg_cl3 = 1'b1;
    idle(6);
    base = n_col;
    req_write = 1'b0; req_bank = 2'd2; req_row = 13'd1; req_col = 10'd100; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_col = 10'd104;
    while (!req_ready) @(negedge clk);
    acc = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_col(base + 2);
    gap = bl8 ? 4 : 2;
    chk(last_col - prev_col == gap, "R8 back-to-back spacing", last_col - prev_col, gap);
    chk(col_addr == 13'd104, "R11 second column", int'(col_addr), 104);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  initial begin
    int r, acc;
    for (int i = 0; i < 4; i++) begin last_act[i] = -1000; last_pre[i] = -1000; sb_open[i] = 1'b0; end
    idle(3);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R2 strobes in reset", int'({cs_n, ras_n, cas_n, we_n}), 15);
    chk(!rd_start, "R2 rd_start in reset", rd_start, 0);
    chk(req_ready, "R2 ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R2 strobes after reset", int'({cs_n, ras_n, cas_n, we_n}), 15);
    chk(req_ready, "R2 ready after reset", req_ready, 1);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);
    for (int i = 0; i < 4; i++) chk(sb_open[i], "R6 all banks open", sb_open[i], 1);

    run_pair(1'b0);
    run_pair(1'b1);

    n_pre_ref = 0;
    while (n_ref < 1 && cyc < 19000) @(posedge clk);
    chk(n_pre_ref == 4, "R9 precharges before refresh", n_pre_ref, 4);
    for (int i = 0; i < 4; i++) chk(pre_log[i] == i, "R9 precharge order", pre_log[i], i);
    chk(ref_log[0] - last_pre[3] == TRP, "R9 refresh spacing", ref_log[0] - last_pre[3], TRP);
    r = ref_log[0];
    while (cyc < r + TRFC - 2) @(negedge clk);
    chk(!req_ready, "R10 ready low in refresh recovery", req_ready, 0);
    @(negedge clk);
    chk(req_ready, "R10 ready back after recovery", req_ready, 1);

    offer(1'b0, 2'd1, 13'd7, 10'd2, acc);
    wait_col(n_col + 1);
    chk(col_cyc - acc == 1 + TRCD, "R9 bank reopened after refresh", col_cyc - acc, 1 + TRCD);

    while (n_ref < 4 && cyc < 19000) @(posedge clk);
    chk(ref_log[3] - ref_log[2] == REF_IVL, "R9 refresh interval", ref_log[3] - ref_log[2], REF_IVL);
    idle(4);
    done = 1'b1;
    finish_run();
  end
endmodule